// File: doc/BRIEF.md
# Strided Two-Dimensional DMA Channel Address Generator

This block is a single channel of a two-dimensional DMA engine. Software fills a small set of configuration registers through a one-cycle write port. A write to the start-address register, made while the channel is idle, starts a transfer. The channel then presents a stream of word addresses on a memory request port with a valid/ready handshake. Data movement, the bus fabric and arbitration between channels are handled elsewhere.

In strided mode the channel walks `rows = ylen + 1` rows. Each row is `xlen` consecutive words, and row `r` begins at `base + r * stride`. When `xlen` is zero the channel runs in loop mode instead. It sweeps an area of `stride * (ylen + 1)` words one word at a time and wraps back to `base` at the end of the area. It flags a status event at the end of the first half of the area and another at the end of the whole area. All addresses and lengths are counted in 32-bit words.

A single status bit records completion and loop events. Software clears it by writing 1. It reaches the interrupt line only while the enable bit is set. A halt command stops a running transfer without reporting completion.

Top module: `dma2d_chan`

Register offsets (byte offsets on `reg_off`): 0x00 start address (a write starts the transfer), 0x04 row length, 0x08 row count minus one, 0x0C control, 0x10 stride, 0x14 interrupt enable (bit 0), 0x18 status (write 1 to bit 0 to clear), 0x1C halt (write 1 to bit 0), 0x20 loop control (bits `CH_ID` and `CH_ID+16`).

## Requirements
- R1: After synchronous reset, `busy`, `mem_valid` and `irq` are all 0.
- R2: A strided transfer presents exactly `(ylen+1)*xlen` addresses. The word with index `k` has address `base + (k / xlen) * stride + (k % xlen)`.
- R3: On the clock edge that accepts the last word of a strided transfer, the channel returns to idle and sets its status bit. A later start is accepted.
- R4: While `mem_valid` is 1 and `mem_ready` is 0, `mem_valid` stays 1 and `mem_addr` holds its value. No word is skipped or repeated.
- R5: A write to offset 0x00 starts a transfer only while `busy` is 0. A write to offset 0x00 during a transfer leaves the running address sequence unchanged.
- R6: With `xlen` = 0, word `k` has address `base + (k mod stride*(ylen+1))`. The sequence wraps to `base` after the last word of the area.
- R7: In loop mode the status bit is set when the word at area offset `stride*(ylen+1)/2 - 1` is accepted, and again when the last word of the area is accepted. It is not set before either of these.
- R8: Loop mode continues while either loop-control bit (`CH_ID` or `CH_ID+16` of offset 0x20) is 1. Once both bits are 0, the channel finishes the current lap, goes idle and sets the status bit.
- R9: A halt (writing 1 to bit 0 of offset 0x1C) during a transfer keeps the outstanding word valid until it is accepted. The channel is idle on that acceptance edge and does not set the status bit.
- R10: Writing 1 to bit 0 of offset 0x18 clears the status bit. `irq` equals the status bit ANDed with enable bit 0 of offset 0x14, so the status bit is kept while the enable bit is 0.
- R11: Control bit 4 (bursts of four words) drives `mem_burst4` and control bit 5 (memory to device) drives `mem_to_dev` for the whole transfer. Control bits 3:0 carry the channel number and do not affect the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe, one cycle per write |
| reg_off | input | 6 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| mem_valid | output | 1 | Address request valid |
| mem_addr | output | AW (30) | Word address of the request |
| mem_ready | input | 1 | Memory port accepts the request |
| mem_burst4 | output | 1 | Transfer uses four-word bursts |
| mem_to_dev | output | 1 | Direction: 1 memory to device, 0 device to memory |
| irq | output | 1 | Status bit gated by interrupt enable |
| busy | output | 1 | Transfer in progress |

## Verification
The hardest situation to reach from the ports is a halt that arrives while a word is stalled. The channel must keep that word presented, complete its handshake and then stop without raising status. The bench reaches it by holding `mem_ready` low, issuing the halt write, watching the stalled address for a cycle, and only then granting one handshake. The loop-mode half and end events, and the wrap back to the base address, come from a directed lap sequence. Each ready phase is followed by a status check and a write-1 clear. Randomised strided transfers with random backpressure cover the rest.

// File: rtl/dma2d_pkg.sv
// Shared register offsets and walker state type for the 2D DMA channel.
package dma2d_pkg;
    localparam int OFF_W = 6;

    localparam logic [OFF_W-1:0] OFF_START  = 6'h00;
    localparam logic [OFF_W-1:0] OFF_ROWLEN = 6'h04;
    localparam logic [OFF_W-1:0] OFF_ROWS   = 6'h08;
    localparam logic [OFF_W-1:0] OFF_CTRL   = 6'h0C;
    localparam logic [OFF_W-1:0] OFF_STRIDE = 6'h10;
    localparam logic [OFF_W-1:0] OFF_IEN    = 6'h14;
    localparam logic [OFF_W-1:0] OFF_STAT   = 6'h18;
    localparam logic [OFF_W-1:0] OFF_HALT   = 6'h1C;
    localparam logic [OFF_W-1:0] OFF_LOOP   = 6'h20;

    localparam int CTRL_BURST_BIT = 4;
    localparam int CTRL_DIR_BIT   = 5;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } walk_state_t;
endpackage

// File: rtl/dma2d_regs.sv
// Register file of one DMA channel.
// Holds the configuration, the status bit (write-1-to-clear) and the
// interrupt enable. It decodes the start and halt commands into one-cycle
// pulses. Assumes one write per strobe cycle and CH_ID < 16.
module dma2d_regs #(
    parameter int AW    = 30,
    parameter int LW    = 16,
    parameter int CH_ID = 0
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          reg_wr,
    input  logic [dma2d_pkg::OFF_W-1:0]   reg_off,
    input  logic [31:0]                   reg_wdata,
    input  logic                          busy,
    input  logic                          evt_set,
    output logic                          start,
    output logic [AW-1:0]                 start_base,
    output logic [LW-1:0]                 cfg_rowlen,
    output logic [LW-1:0]                 cfg_rows,
    output logic [LW-1:0]                 cfg_stride,
    output logic                          cfg_burst,
    output logic                          cfg_dir,
    output logic                          loop_on,
    output logic                          halt_req,
    output logic                          irq
);
    import dma2d_pkg::*;

    logic status_q;
    logic ien_q;
    logic loop_lo_q;
    logic loop_hi_q;
    logic clr_stat;
    logic unused_wdata;

    // Decode a write of each command register.
    assign start      = reg_wr && (reg_off == OFF_START) && !busy;
    assign halt_req   = reg_wr && (reg_off == OFF_HALT) && reg_wdata[0];
    assign clr_stat   = reg_wr && (reg_off == OFF_STAT) && reg_wdata[0];
    assign start_base = reg_wdata[AW-1:0];
    assign loop_on    = loop_lo_q || loop_hi_q;
    assign irq        = status_q && ien_q;
    assign unused_wdata = ^reg_wdata;

    // Capture configuration fields on writes to their offsets.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_rowlen <= '0;
            cfg_rows   <= '0;
            cfg_stride <= '0;
            cfg_burst  <= 1'b0;
            cfg_dir    <= 1'b0;
            ien_q      <= 1'b0;
            loop_lo_q  <= 1'b0;
            loop_hi_q  <= 1'b0;
        end else if (reg_wr) begin
            case (reg_off)
                OFF_ROWLEN: cfg_rowlen <= reg_wdata[LW-1:0];
                OFF_ROWS:   cfg_rows   <= reg_wdata[LW-1:0];
                OFF_STRIDE: cfg_stride <= reg_wdata[LW-1:0];
                OFF_CTRL: begin
                    cfg_burst <= reg_wdata[CTRL_BURST_BIT];
                    cfg_dir   <= reg_wdata[CTRL_DIR_BIT];
                end
                OFF_IEN:    ien_q <= reg_wdata[0];
                OFF_LOOP: begin
                    loop_lo_q <= reg_wdata[CH_ID];
                    loop_hi_q <= reg_wdata[CH_ID+16];
                end
                default: ;
            endcase
        end
    end

    // Status bit: a set event wins over a write-1 clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)        status_q <= 1'b0;
        else if (evt_set)  status_q <= 1'b1;
        else if (clr_stat) status_q <= 1'b0;
    end

    // R10: a clear with no set event leaves the interrupt low.
    p_clear_drops_irq_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_stat && !evt_set) |=> !irq);

    // R10: a set event with the enable held reaches the interrupt line.
    p_event_raises_irq_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_set && ien_q && !(reg_wr && reg_off == OFF_IEN)) |=> irq);

    // R5: a start is only decoded while the walker is idle.
    p_start_only_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !busy);
endmodule

// File: rtl/dma2d_walker.sv
// Address walker of one DMA channel.
// In strided mode it steps through rows of rowlen words spaced by the
// stride. With rowlen == 0 it sweeps a circular area of stride*(rows+1)
// words. It takes a snapshot of the configuration at start. Only the loop
// enable is read live. Assumes stride >= 1 in loop mode.
module dma2d_walker #(
    parameter int AW = 30,
    parameter int LW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [AW-1:0] start_base,
    input  logic [LW-1:0] cfg_rowlen,
    input  logic [LW-1:0] cfg_rows,
    input  logic [LW-1:0] cfg_stride,
    input  logic          cfg_burst,
    input  logic          cfg_dir,
    input  logic          loop_on,
    input  logic          halt_req,
    input  logic          mem_ready,
    output logic          mem_valid,
    output logic [AW-1:0] mem_addr,
    output logic          mem_burst4,
    output logic          mem_to_dev,
    output logic          busy,
    output logic          evt_done,
    output logic          evt_half,
    output logic          evt_lap
);
    import dma2d_pkg::*;

    localparam int AREA_W = 2 * LW + 1;

    walk_state_t       state_q;
    logic              loop_q;
    logic              halt_pend_q;
    logic [AW-1:0]     base_q;
    logic [AW-1:0]     row_base_q;
    logic [AW-1:0]     cur_q;
    logic [LW-1:0]     rowlen_q;
    logic [LW-1:0]     rows_q;
    logic [LW-1:0]     stride_q;
    logic [LW-1:0]     col_q;
    logic [LW-1:0]     row_q;
    logic [AREA_W-1:0] off_q;
    logic [AREA_W-1:0] area_last_q;
    logic [AREA_W-1:0] half_last_q;
    logic [AREA_W-1:0] area_c;
    logic              hs;
    logic              hs_live;
    logic              row_end;
    logic              last_row;
    logic              area_end;
    logic [AW-1:0]     next_row_base;

    // Loop area size computed from the configuration at start time.
    assign area_c = AREA_W'(cfg_stride) * (AREA_W'(cfg_rows) + AREA_W'(1));

    assign busy          = (state_q == ST_RUN);
    assign mem_valid     = busy;
    assign mem_addr      = cur_q;
    assign hs            = busy && mem_ready;
    assign hs_live       = hs && !halt_pend_q && !halt_req;
    assign row_end       = (col_q == rowlen_q - LW'(1));
    assign last_row      = (row_q == rows_q);
    assign area_end      = (off_q == area_last_q);
    assign next_row_base = row_base_q + AW'(stride_q);

    // Status events, one cycle wide, on the accepting edge.
    assign evt_done = hs_live && !loop_q && row_end && last_row;
    assign evt_lap  = hs_live && loop_q && area_end;
    assign evt_half = hs_live && loop_q && (off_q == half_last_q);

    // Sequencer: start, per-word stepping, row change, wrap and halt.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            loop_q      <= 1'b0;
            halt_pend_q <= 1'b0;
            base_q      <= '0;
            row_base_q  <= '0;
            cur_q       <= '0;
            rowlen_q    <= '0;
            rows_q      <= '0;
            stride_q    <= '0;
            col_q       <= '0;
            row_q       <= '0;
            off_q       <= '0;
            area_last_q <= '0;
            half_last_q <= '0;
            mem_burst4  <= 1'b0;
            mem_to_dev  <= 1'b0;
        end else if (state_q == ST_IDLE) begin
            if (start) begin
                state_q     <= ST_RUN;
                loop_q      <= (cfg_rowlen == '0);
                halt_pend_q <= 1'b0;
                base_q      <= start_base;
                row_base_q  <= start_base;
                cur_q       <= start_base;
                rowlen_q    <= cfg_rowlen;
                rows_q      <= cfg_rows;
                stride_q    <= cfg_stride;
                col_q       <= '0;
                row_q       <= '0;
                off_q       <= '0;
                area_last_q <= area_c - AREA_W'(1);
                half_last_q <= (area_c >> 1) - AREA_W'(1);
                mem_burst4  <= cfg_burst;
                mem_to_dev  <= cfg_dir;
            end
        end else begin
            if (halt_req) halt_pend_q <= 1'b1;
            if (hs) begin
                if (halt_pend_q || halt_req) begin
                    state_q <= ST_IDLE;
                end else if (loop_q) begin
                    if (area_end) begin
                        off_q <= '0;
                        cur_q <= base_q;
                        if (!loop_on) state_q <= ST_IDLE;
                    end else begin
                        off_q <= off_q + AREA_W'(1);
                        cur_q <= cur_q + AW'(1);
                    end
                end else if (row_end) begin
                    if (last_row) begin
                        state_q <= ST_IDLE;
                    end else begin
                        row_q      <= row_q + LW'(1);
                        col_q      <= '0;
                        row_base_q <= next_row_base;
                        cur_q      <= next_row_base;
                    end
                end else begin
                    col_q <= col_q + LW'(1);
                    cur_q <= cur_q + AW'(1);
                end
            end
        end
    end

    // R4: a stalled request keeps its address and stays valid.
    p_stall_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr)));

    // R3: the final strided word leaves the channel idle.
    p_done_goes_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        evt_done |=> !busy);

    // R9: the handshake after a halt ends the transfer.
    p_halt_stops_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (hs && halt_pend_q) |=> !busy);

    // R6: the end of the loop area returns to the base address.
    p_wrap_to_base_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (hs && loop_q && area_end && !halt_pend_q && !halt_req)
        |=> (!busy || mem_addr == base_q));

    // R7: at most one status event per accepted word.
    p_single_event_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({evt_done, evt_half, evt_lap}));

    // R11: the transfer attributes stay fixed while a transfer runs.
    p_attr_stable_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && $past(mem_valid)) |-> $stable({mem_burst4, mem_to_dev}));
endmodule

// File: rtl/dma2d_chan.sv
// One channel of a strided two-dimensional DMA engine.
// Joins the register file and the address walker. Word addresses leave on
// a valid/ready port. Completion and loop events set a status bit, which
// the interrupt enable gates onto irq.
module dma2d_chan #(
    parameter int AW    = 30,
    parameter int LW    = 16,
    parameter int CH_ID = 0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr,
    input  logic [5:0]    reg_off,
    input  logic [31:0]   reg_wdata,
    output logic          mem_valid,
    output logic [AW-1:0] mem_addr,
    input  logic          mem_ready,
    output logic          mem_burst4,
    output logic          mem_to_dev,
    output logic          irq,
    output logic          busy
);
    logic          start;
    logic [AW-1:0] start_base;
    logic [LW-1:0] cfg_rowlen;
    logic [LW-1:0] cfg_rows;
    logic [LW-1:0] cfg_stride;
    logic          cfg_burst;
    logic          cfg_dir;
    logic          loop_on;
    logic          halt_req;
    logic          evt_done;
    logic          evt_half;
    logic          evt_lap;
    logic          evt_set;

    // Any walker event sets the status bit.
    assign evt_set = evt_done || evt_half || evt_lap;

    dma2d_regs #(.AW(AW), .LW(LW), .CH_ID(CH_ID)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_wr     (reg_wr),
        .reg_off    (reg_off),
        .reg_wdata  (reg_wdata),
        .busy       (busy),
        .evt_set    (evt_set),
        .start      (start),
        .start_base (start_base),
        .cfg_rowlen (cfg_rowlen),
        .cfg_rows   (cfg_rows),
        .cfg_stride (cfg_stride),
        .cfg_burst  (cfg_burst),
        .cfg_dir    (cfg_dir),
        .loop_on    (loop_on),
        .halt_req   (halt_req),
        .irq        (irq)
    );

    dma2d_walker #(.AW(AW), .LW(LW)) u_walker (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .start_base (start_base),
        .cfg_rowlen (cfg_rowlen),
        .cfg_rows   (cfg_rows),
        .cfg_stride (cfg_stride),
        .cfg_burst  (cfg_burst),
        .cfg_dir    (cfg_dir),
        .loop_on    (loop_on),
        .halt_req   (halt_req),
        .mem_ready  (mem_ready),
        .mem_valid  (mem_valid),
        .mem_addr   (mem_addr),
        .mem_burst4 (mem_burst4),
        .mem_to_dev (mem_to_dev),
        .busy       (busy),
        .evt_done   (evt_done),
        .evt_half   (evt_half),
        .evt_lap    (evt_lap)
    );

    // R1: nothing is requested while idle.
    p_valid_iff_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid == busy);
endmodule

// File: tb/dma2d_chan_bench.sv
// Self-checking bench: directed corner cases plus seeded random strided runs.
module dma2d_chan_bench;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 30;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_wr = 1'b0;
    logic [5:0]    reg_off = '0;
    logic [31:0]   reg_wdata = '0;
    logic          mem_valid;
    logic [AW-1:0] mem_addr;
    logic          mem_ready = 1'b0;
    logic          mem_burst4;
    logic          mem_to_dev;
    logic          irq;
    logic          busy;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    int g_base, g_x, g_y, g_s, g_k, g_rdy;
    bit g_loop;

    always #(CLK_PERIOD/2) clk = ~clk;

    dma2d_chan #(.AW(AW), .LW(16), .CH_ID(0)) u_dma2d_chan (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_off(reg_off),
        .reg_wdata(reg_wdata), .mem_valid(mem_valid), .mem_addr(mem_addr),
        .mem_ready(mem_ready), .mem_burst4(mem_burst4),
        .mem_to_dev(mem_to_dev), .irq(irq), .busy(busy)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [AW-1:0] exp_addr(input int k);
        int area;
        if (g_loop) begin
            area = g_s * (g_y + 1);
            return AW'(g_base + (k % area));
        end
        return AW'(g_base + (k / g_x) * g_s + (k % g_x));
    endfunction

    task automatic wr(input logic [5:0] o, input logic [31:0] d);
        reg_wr = 1'b1; reg_off = o; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic start_xfer(input int base, input int x, input int y, input int s,
                              input logic [31:0] ctrl, input bit ien, input logic [31:0] loopbits);
        wr(6'h04, x); wr(6'h08, y); wr(6'h10, s); wr(6'h0C, ctrl);
        wr(6'h14, {31'd0, ien}); wr(6'h20, loopbits);
        g_base = base; g_x = x; g_y = y; g_s = s; g_k = 0; g_loop = (x == 0);
        wr(6'h00, base);
    endtask

    // Accept up to n words with random backpressure, checking each address.
    task automatic pump(input int n, output int got);
        bit prev_stall = 0;
        logic [AW-1:0] prev_addr = '0;
        bit rdy;
        got = 0;
        while (got < n && busy) begin
            if (prev_stall)
                check(mem_valid && mem_addr == prev_addr, "R4 stall hold", mem_addr, prev_addr);
            rdy = (($urandom % 100) < g_rdy);
            mem_ready = rdy;
            if (mem_valid && rdy) begin
                check(mem_addr == exp_addr(g_k), "R2/R6 address", mem_addr, exp_addr(g_k));
                g_k++; got++;
            end
            prev_stall = mem_valid && !rdy;
            prev_addr  = mem_addr;
            @(negedge clk);
        end
        mem_ready = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        int got;
        int x, y, s, b;
        bit ien;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(!busy && !mem_valid && !irq, "R1 reset", {busy, mem_valid, irq}, 0);

        // R11 control flags, R2/R3 basic strided run, full ready
        g_rdy = 100;
        start_xfer(32'h100, 3, 1, 5, 32'h30, 1'b1, 0);
        check(mem_burst4 && mem_to_dev, "R11 flags set", {mem_burst4, mem_to_dev}, 3);
        pump(1000, got);
        check(got == 6, "R2 word count", got, 6);
        check(!busy && irq, "R3 done status", {busy, irq}, 1);
        wr(6'h18, 1);
        check(!irq, "R10 clear", irq, 0);
        start_xfer(32'h40, 2, 0, 2, 32'h0F, 1'b0, 0);
        check(!mem_burst4 && !mem_to_dev, "R11 channel bits only", {mem_burst4, mem_to_dev}, 0);
        pump(1000, got);
        wr(6'h18, 1);
        start_xfer(32'h40, 2, 0, 2, 32'h10, 1'b0, 0);
        check(mem_burst4 && !mem_to_dev, "R11 burst only", {mem_burst4, mem_to_dev}, 2);
        pump(1000, got);
        wr(6'h18, 1);

        // R5 start write while busy is ignored
        g_rdy = 60;
        start_xfer(32'h200, 4, 2, 8, 0, 1'b1, 0);
        pump(5, got);
        wr(6'h00, 32'h9000);
        pump(1000, got);
        check(g_k == 12, "R5 sequence unchanged", g_k, 12);
        check(!busy && irq, "R3 done after ignored start", {busy, irq}, 1);
        wr(6'h18, 1);

        // R9 halt during a stalled word
        g_rdy = 100;
        start_xfer(32'h300, 8, 3, 8, 0, 1'b1, 0);
        pump(3, got);
        wr(6'h1C, 1);
        check(busy && mem_valid && mem_addr == exp_addr(g_k), "R9 outstanding word kept", mem_addr, exp_addr(g_k));
        mem_ready = 1'b1;
        @(negedge clk);
        mem_ready = 1'b0;
        check(!busy && !mem_valid, "R9 idle after handshake", busy, 0);
        check(!irq, "R9 no completion status", irq, 0);

        // R6/R7/R8 loop mode: area 8 words, half after 4
        g_rdy = 100;
        start_xfer(32'h2000, 0, 3, 2, 0, 1'b1, 32'h0001_0001);
        pump(3, got);
        check(!irq, "R7 no event before half", irq, 0);
        pump(1, got);
        check(irq, "R7 half event", irq, 1);
        wr(6'h18, 1);
        check(!irq, "R10 clear in loop", irq, 0);
        pump(4, got);
        check(irq, "R7 lap event", irq, 1);
        wr(6'h18, 1);
        g_rdy = 50;
        pump(3, got);
        check(busy && g_k == 11, "R6 wrap continues", g_k, 11);
        wr(6'h20, 32'h0001_0000);
        pump(5, got);
        check(busy, "R8 one bit keeps looping", busy, 1);
        wr(6'h20, 0);
        wr(6'h18, 1);
        pump(1000, got);
        check(got == 8 && !busy, "R8 stops at lap end", got, 8);
        check(irq, "R8 completion status", irq, 1);
        wr(6'h18, 1);

        // Random strided transfers, R2/R3/R10
        for (int i = 0; i < 24; i++) begin
            x = 1 + $urandom % 6; y = $urandom % 5; s = x + $urandom % 4;
            b = $urandom % 32'h10000; ien = $urandom % 2;
            g_rdy = 40 + $urandom % 60;
            start_xfer(b, x, y, s, 0, ien, 0);
            pump(1000, got);
            check(got == (y + 1) * x && !busy, "R2 random count", got, (y + 1) * x);
            check(irq == ien, "R10 irq gating", irq, ien);
            if (!ien) begin
                wr(6'h14, 1);
                check(irq, "R10 status kept while disabled", irq, 1);
            end
            wr(6'h18, 1);
            check(!irq, "R10 clear after run", irq, 0);
        end

        finished = 1;
        $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule